// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Banking

This block gives a host a byte-wide configuration window made of two I/O locations: an index location (address bit 0 = 0) and a data location (address bit 0 = 1). After reset the window is locked. The host opens it by writing the unlock byte 0x87 to the index location twice in a row. It closes it again by writing 0xAA to the index location. While the window is open, a byte written to the index location picks a register. The data location then reads or writes that register.

Registers below 0x30 are global. They include a logical-device selector at 0x07 and read-only identification bytes at 0x20 to 0x24. Registers from 0x30 upward are stored once for each logical device, and the device selector picks which copy is visible. Bit 0 of register 0x30 is the enable of its device and appears on a per-device output.

Host requests use a valid/ready channel. `req_ready` is always high, so the block never applies back-pressure and a request is taken on every clock edge that sees `req_valid`. A read returns its byte on `rsp_valid`/`rsp_data` in the next cycle. The response has no ready signal, so the host must take it in that cycle. `rsp_data` keeps its value until the next read.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked, the latched index is 0x00, the device selector is 0, every stored register is 0x00, `ldev_enable` is all zero and `rsp_valid` is low.
- R2: Two consecutive index-location writes of 0x87 open the window. `cfg_mode` rises in the cycle after the second write is taken, and that second write is not latched as an index.
- R3: A single 0x87 followed by an index-location write of any other value returns the key detector to idle. A further lone 0x87 does not open the window. Data-location accesses do not advance or reset the key detector.
- R4: While the window is open, an index-location write of 0xAA locks it and clears the latched index to 0x00.
- R5: While the window is locked, every read from either location returns 0xFF and data-location writes change no register.
- R6: `req_ready` is always high. Every accepted read raises `rsp_valid` for exactly the next cycle, carrying the value the register held when the read was taken. Writes produce no response.
- R7: Register 0x07 is a writable byte that holds the logical-device selector and reads back as written.
- R8: Registers 0x20/0x21 read the 16-bit device ID (high byte at 0x20), 0x22 reads the revision, and 0x23/0x24 read the manufacturer ID 0x1934 (0x19 at 0x23). Writes to 0x20 to 0x24 are ignored.
- R9: Registers 0x30 to 0xFF are stored separately for each logical device. Accesses go to the copy chosen by the selector value at the time of the access.
- R10: `ldev_enable[n]` equals bit 0 of register 0x30 of device n. It changes in the cycle after the write that sets or clears that bit.
- R11: When the selector is NUM_LDEV or larger, reads of 0x30 and above return 0xFF and writes there change nothing.
- R12: Global registers 0x00 to 0x2F (other than 0x07 and 0x20 to 0x24) are read/write bytes shared by all devices.
- R13: While the window is open, a read of the index location returns the latched index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | 1 | 0 = index location, 1 = data location |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_data | output | 8 | Read response byte |
| cfg_mode | output | 1 | Configuration window open |
| ldev_enable | output | NUM_LDEV | Bit 0 of register 0x30 of each logical device |

## Verification
A key detector stuck in the wrong state shows up within one cycle. `cfg_mode` differs from the reference, and the next data read returns 0xFF where a register value was expected, or a register value where 0xFF was expected. A wrong latched index or a wrong bank selection is not visible until the host reads back. The bench therefore reads every register it has written, and reads it again after the selector has moved away and back. Enable bits are compared against the reference on every clock, so a write that lands in the wrong bank shows on `ldev_enable` in the following cycle.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_OPEN_BYTE  = 8'h87;
  localparam logic [7:0] KEY_CLOSE_BYTE = 8'hAA;
  localparam logic [7:0] IDX_DEV_SEL    = 8'h07;
  localparam logic [7:0] IDX_ID_HI      = 8'h20;
  localparam logic [7:0] IDX_ID_LO      = 8'h21;
  localparam logic [7:0] IDX_REV        = 8'h22;
  localparam logic [7:0] IDX_VEND_HI    = 8'h23;
  localparam logic [7:0] IDX_VEND_LO    = 8'h24;
  localparam int         BANK_BASE      = 8'h30;
  localparam int         BANK_SPAN      = 256 - BANK_BASE;
  localparam logic [7:0] LOCKED_READ    = 8'hFF;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic       idx_load,
  output logic       idx_clear
);
  key_state_e state_q;
  logic is_open_key, is_close_key;

  assign is_open_key  = (wdata == KEY_OPEN_BYTE);
  assign is_close_key = (wdata == KEY_CLOSE_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KS_LOCKED;
    end else if (idx_wr) begin
      case (state_q)
        KS_LOCKED: if (is_open_key) state_q <= KS_ARMED;
        KS_ARMED:  state_q <= is_open_key ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (is_close_key) state_q <= KS_LOCKED;
        default:   state_q <= KS_LOCKED;
      endcase
    end
  end

  assign open      = (state_q == KS_OPEN);
  assign idx_load  = idx_wr && open && !is_close_key;
  assign idx_clear = idx_wr && open && is_close_key;
endmodule

// File: rtl/sio_index_latch.sv
module sio_index_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       clear,
  input  logic [7:0] din,
  output logic [7:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)     idx <= 8'h00;
    else if (clear) idx <= 8'h00;
    else if (load)  idx <= din;
  end
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID    = 16'h0A15,
  parameter logic [7:0]  DEV_REV   = 8'h11,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] dev_sel
);
  localparam int GLOB_N = BANK_BASE;
  localparam int AW     = $clog2(GLOB_N);

  logic [GLOB_N-1:0][7:0] view;
  logic [AW-1:0]          a_lo;

  assign a_lo = addr[AW-1:0];

  for (genvar i = 0; i < GLOB_N; i++) begin : g_reg
    if (i == int'(IDX_ID_HI)) begin : g_idh
      assign view[i] = DEV_ID[15:8];
    end else if (i == int'(IDX_ID_LO)) begin : g_idl
      assign view[i] = DEV_ID[7:0];
    end else if (i == int'(IDX_REV)) begin : g_rev
      assign view[i] = DEV_REV;
    end else if (i == int'(IDX_VEND_HI)) begin : g_vh
      assign view[i] = VENDOR_ID[15:8];
    end else if (i == int'(IDX_VEND_LO)) begin : g_vl
      assign view[i] = VENDOR_ID[7:0];
    end else begin : g_store
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                      q <= 8'h00;
        else if (we && a_lo == AW'(i))   q <= wdata;
      end
      assign view[i] = q;
    end
  end

  assign rdata   = view[a_lo];
  assign dev_sel = view[int'(IDX_DEV_SEL)];
endmodule

// File: rtl/sio_bank_regs.sv
module sio_bank_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDEV = 8,
  localparam int LDN_W   = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1,
  localparam int OFF_W   = $clog2(BANK_SPAN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [LDN_W-1:0]    dev,
  input  logic [OFF_W-1:0]    off,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic [NUM_LDEV-1:0] dev_enable
);
  logic [NUM_LDEV-1:0][7:0] dev_rd;

  for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
    logic [7:0] mem [BANK_SPAN];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < BANK_SPAN; k++) mem[k] <= 8'h00;
      end else if (we && dev == LDN_W'(d)) begin
        mem[off] <= wdata;
      end
    end
    assign dev_rd[d]     = mem[off];
    assign dev_enable[d] = mem[0][0];
  end

  assign rdata = dev_rd[dev];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDEV  = 8,
  parameter logic [15:0] DEV_ID    = 16'h0A15,
  parameter logic [7:0]  DEV_REV   = 8'h11,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_addr,
  input  logic                req_write,
  input  logic [7:0]          req_wdata,
  output logic                rsp_valid,
  output logic [7:0]          rsp_data,
  output logic                cfg_mode,
  output logic [NUM_LDEV-1:0] ldev_enable
);
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam int OFF_W = $clog2(BANK_SPAN);

  logic       idx_wr, dat_wr, rd_en;
  logic       open, idx_load, idx_clear;
  logic [7:0] idx, glob_rd, bank_rd, dev_sel, rd_val;
  logic       in_bank, dev_ok;
  logic [7:0] off_full;

  assign req_ready = 1'b1;
  assign idx_wr    = req_valid && req_write && !req_addr;
  assign dat_wr    = req_valid && req_write &&  req_addr;
  assign rd_en     = req_valid && !req_write;

  sio_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(req_wdata),
    .open(open), .idx_load(idx_load), .idx_clear(idx_clear)
  );

  sio_index_latch u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_load), .clear(idx_clear),
    .din(req_wdata), .idx(idx)
  );

  assign in_bank  = (idx >= 8'(BANK_BASE));
  assign dev_ok   = (int'(dev_sel) < NUM_LDEV);
  assign off_full = idx - 8'(BANK_BASE);

  sio_global_regs #(
    .DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .VENDOR_ID(VENDOR_ID)
  ) u_glob (
    .clk(clk), .rst_n(rst_n),
    .we(dat_wr && open && !in_bank),
    .addr(idx), .wdata(req_wdata),
    .rdata(glob_rd), .dev_sel(dev_sel)
  );

  sio_bank_regs #(.NUM_LDEV(NUM_LDEV)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(dat_wr && open && in_bank && dev_ok),
    .dev(dev_sel[LDN_W-1:0]), .off(off_full[OFF_W-1:0]),
    .wdata(req_wdata), .rdata(bank_rd), .dev_enable(ldev_enable)
  );

  always_comb begin
    if (!open)          rd_val = LOCKED_READ;
    else if (!req_addr) rd_val = idx;
    else if (!in_bank)  rd_val = glob_rd;
    else if (dev_ok)    rd_val = bank_rd;
    else                rd_val = LOCKED_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_val;
    end
  end

  assign cfg_mode = open;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int NUM_LDEV = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_addr,
  input logic                req_write,
  input logic [7:0]          req_wdata,
  input logic                rsp_valid,
  input logic [7:0]          rsp_data,
  input logic                cfg_mode,
  input logic [NUM_LDEV-1:0] ldev_enable
);
  AST_RD_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R6
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R6
  AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && req_valid && !req_write) |=> (rsp_data == 8'hFF)); // R5
  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(req_valid && req_write && !req_addr && req_wdata == 8'h87)); // R2
  AST_CLOSE_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && req_valid && req_write && !req_addr && req_wdata == 8'hAA) |=> !cfg_mode); // R4
  AST_LOCKED_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(ldev_enable)); // R5
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_LDEV(NUM_LDEV)) u_chk (.*);

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
module tb_sio_cfg_port;
  localparam int NL = 8;
  localparam logic [15:0] DID = 16'h0A15;
  localparam logic [7:0]  DREV = 8'h11;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_addr = 0, req_write = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, cfg_mode;
  logic [7:0] rsp_data;
  logic [NL-1:0] ldev_enable;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sio_cfg_port #(.NUM_LDEV(NL), .DEV_ID(DID), .DEV_REV(DREV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_mode(cfg_mode),
    .ldev_enable(ldev_enable)
  );

  // behavioural reference
  int m_key;            // 0 idle, 1 one key seen, 2 open
  int m_idx;
  int m_g [48];
  int m_b [NL][256];
  bit m_rv;
  int m_rd;

  function automatic int ref_read(bit a);
    int sel;
    if (m_key != 2) return 255;
    if (!a) return m_idx;
    if (m_idx < 48) begin
      case (m_idx)
        32: return int'(DID[15:8]);
        33: return int'(DID[7:0]);
        34: return int'(DREV);
        35: return 8'h19;
        36: return 8'h34;
        default: return m_g[m_idx];
      endcase
    end
    sel = m_g[7];
    if (sel >= NL) return 255;
    return m_b[sel][m_idx];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key = 0; m_idx = 0; m_rv = 0; m_rd = 0;
      foreach (m_g[i]) m_g[i] = 0;
      foreach (m_b[i, j]) m_b[i][j] = 0;
    end else begin
      m_rv = 0;
      if (req_valid && !req_write) begin
        m_rv = 1; m_rd = ref_read(req_addr);
      end else if (req_valid && !req_addr) begin
        if (m_key == 0) begin if (req_wdata == 8'h87) m_key = 1; end
        else if (m_key == 1) m_key = (req_wdata == 8'h87) ? 2 : 0;
        else if (req_wdata == 8'hAA) begin m_key = 0; m_idx = 0; end
        else m_idx = req_wdata;
      end else if (req_valid && m_key == 2) begin
        if (m_idx < 48) begin
          if (m_idx < 32 || m_idx > 36) m_g[m_idx] = req_wdata;
        end else if (m_g[7] < NL) m_b[m_g[7]][m_idx] = req_wdata;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == 1'b1, "R6 ready", req_ready, 1);
      chk(cfg_mode == (m_key == 2), "R2 cfg_mode", cfg_mode, m_key == 2);
      chk(rsp_valid == m_rv, "R6 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk(rsp_data == m_rd[7:0], "R9 rsp_data", rsp_data, m_rd);
      for (int d = 0; d < NL; d++)
        chk(ldev_enable[d] == m_b[d][48][0], "R10 ldev_enable", ldev_enable[d], m_b[d][48][0]);
    end
  end

  task automatic op(bit a, bit w, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd_exp(bit a, logic [7:0] exp, string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, tag, rsp_valid, 1);
    chk(rsp_data === exp, tag, rsp_data, exp);
  endtask

  task automatic reg_wr(logic [7:0] i, logic [7:0] d);
    op(0, 1, i); op(1, 1, d);
  endtask

  task automatic reg_rd(logic [7:0] i, logic [7:0] exp, string tag);
    op(0, 1, i); rd_exp(1, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_mode == 0, "R1 locked after reset", cfg_mode, 0);
    chk(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);
    chk(ldev_enable == '0, "R1 enables clear", ldev_enable, 0);

    // locked window
    rd_exp(1, 8'hFF, "R5 locked data read");
    rd_exp(0, 8'hFF, "R5 locked index read");
    op(1, 1, 8'h5C);
    op(0, 1, 8'h30); op(1, 1, 8'h01);
    chk(ldev_enable == '0, "R5 locked write ignored", ldev_enable, 0);

    // key detector
    op(0, 1, 8'h87); op(0, 1, 8'h55);
    chk(cfg_mode == 0, "R3 broken key", cfg_mode, 0);
    op(0, 1, 8'h87);
    op(1, 0, 8'h00);
    chk(cfg_mode == 0, "R3 lone key", cfg_mode, 0);
    op(0, 1, 8'h87);
    chk(cfg_mode == 1, "R2 unlock", cfg_mode, 1);
    rd_exp(0, 8'h00, "R13 index after unlock");
    reg_rd(8'h00, 8'h00, "R1 global reset value");
    reg_rd(8'h30, 8'h00, "R5 locked write left no trace");

    // identification
    reg_rd(8'h20, DID[15:8], "R8 device id high");
    reg_rd(8'h21, DID[7:0], "R8 device id low");
    reg_rd(8'h22, DREV, "R8 revision");
    reg_rd(8'h23, 8'h19, "R8 vendor high");
    reg_rd(8'h24, 8'h34, "R8 vendor low");
    reg_wr(8'h23, 8'h00);
    reg_rd(8'h23, 8'h19, "R8 id write ignored");
    rd_exp(0, 8'h23, "R13 index readback");

    // globals and selector
    reg_wr(8'h29, 8'h5A);
    reg_rd(8'h29, 8'h5A, "R12 global storage");
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h07, 8'h07, "R7 selector readback");
    reg_wr(8'h30, 8'h01);
    chk(ldev_enable == 8'h80, "R10 enable device 7", ldev_enable, 8'h80);
    reg_wr(8'hF6, 8'h3C);
    reg_wr(8'h07, 8'h00);
    reg_rd(8'hF6, 8'h00, "R9 device 0 separate");
    reg_wr(8'hF6, 8'hC3);
    reg_rd(8'h29, 8'h5A, "R12 global shared");
    reg_wr(8'h07, 8'h07);
    reg_rd(8'hF6, 8'h3C, "R9 device 7 kept");
    reg_wr(8'h30, 8'h00);
    chk(ldev_enable == 8'h00, "R10 enable cleared", ldev_enable, 0);
    reg_wr(8'h30, 8'h03);
    reg_wr(8'h07, 8'h00);
    reg_rd(8'hF6, 8'hC3, "R9 device 0 kept");

    // selector out of range
    reg_wr(8'h07, 8'h09);
    reg_rd(8'h30, 8'hFF, "R11 out-of-range read");
    reg_wr(8'h30, 8'h01);
    chk(ldev_enable == 8'h80, "R11 out-of-range write ignored", ldev_enable, 8'h80);
    reg_wr(8'h07, 8'h01);
    reg_rd(8'h30, 8'h00, "R11 device 1 untouched");

    // lock again
    op(0, 1, 8'h45);
    op(0, 1, 8'hAA);
    chk(cfg_mode == 0, "R4 close key", cfg_mode, 0);
    rd_exp(1, 8'hFF, "R5 read after lock");
    op(0, 1, 8'h87); op(0, 1, 8'h87);
    rd_exp(0, 8'h00, "R4 index cleared");
    reg_rd(8'h07, 8'h01, "R7 selector survives lock");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule